// File: doc/BRIEF.md
# Return-to-Zero Handshake Edge Monitor

This block watches one request/acknowledge pair that follows a four-phase, return-to-zero protocol. On every clock it compares the present level of each wire with the level registered one cycle earlier. An edge that the protocol forbids is reported through an error flag and a code that identifies the broken rule. The flag is sticky.

The monitor can be instantiated on the producer side or the consumer side of a handshake buffer. It is passive: it never drives the link. Only the first illegal edge after reset is kept, so the code always names the root cause and not a later consequence of it. While reset is high nothing is checked. The first clock after reset only captures the wire levels.

Top module: `hs_rtz_monitor`

## Requirements
- R1: A clock edge sampled with `rst` high clears `err_flag` to 0 and `err_code` to 0.
- R2: If the previous sample had req=0 and ack=1 and the current sample has req=1, the monitor reports code 1 (request raised while acknowledge still high).
- R3: If the previous sample had req=1 and ack=0 and the current sample has req=0, the monitor reports code 2 (request withdrawn before acknowledge).
- R4: If the previous sample had req=0 and ack=0 and the current sample has ack=1, the monitor reports code 3 (acknowledge without request).
- R5: If the previous sample had req=1 and ack=1 and the current sample has ack=0, the monitor reports code 4 (acknowledge dropped while request still high).
- R6: A link that only makes legal transitions (idle 00, then 10, 11, 01, back to 00, with waits of any length) never raises `err_flag`.
- R7: Once `err_flag` is 1, it stays 1 and `err_code` keeps the first reported code (1 to 4) until reset, whatever further edges occur.
- R8: The first clock edge after `rst` falls only captures req and ack. An illegal jump between the last reset sample and that edge is not reported.
- R9: A violation is visible on `err_flag`/`err_code` right after the clock edge that samples the offending level, with no extra cycle of delay.
- R10: Illegal toggling of req and ack while `rst` is high produces no report, neither during reset nor afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request wire of the observed link |
| ack | input | 1 | Acknowledge wire of the observed link |
| err_flag | output | 1 | Sticky violation indicator |
| err_code | output | 3 | First broken rule: 0 none, 1 to 4 as in R2 to R5 |

## Verification
The monitor holds three kinds of state: the registered req/ack pair, a one-bit armed marker, and the latched report. A wrong previous-level register shows up as a wrong code or as a missing or spurious flag on the very edge that follows it. A wrong armed marker shows up as a report on the first edge after reset, or as a rule that is missed one cycle later. A latch fault becomes visible when a second, different violation overwrites the first code or clears the flag. For that reason the checks compare both outputs after every single edge, and the checks after a violation go on for several cycles.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

    localparam int CODE_W    = 3;
    localparam int NUM_RULES = 4;

    typedef enum logic [CODE_W-1:0] {
        RULE_NONE        = 3'd0,
        RULE_REQ_REARM   = 3'd1,
        RULE_REQ_ABANDON = 3'd2,
        RULE_ACK_UNASKED = 3'd3,
        RULE_ACK_EARLY   = 3'd4
    } rule_e;

    typedef struct packed {
        logic armed;
        logic req;
        logic ack;
    } smp_t;

    typedef struct packed {
        logic  flag;
        rule_e code;
    } lat_t;

endpackage

// File: rtl/hs_edge_sampler.sv
module hs_edge_sampler
    import hs_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    output smp_t prev
);

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d       = smp_q;
        smp_d.req   = req;
        smp_d.ack   = ack;
        smp_d.armed = 1'b1;
        if (rst) begin
            smp_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    assign prev = smp_q;

endmodule

// File: rtl/hs_rule_eval.sv
module hs_rule_eval
    import hs_mon_pkg::*;
(
    input  smp_t  prev,
    input  logic  req,
    input  logic  ack,
    output rule_e hit
);

    logic [NUM_RULES-1:0] viol;

    always_comb begin
        viol[0] = !prev.req &&  prev.ack &&  req;
        viol[1] =  prev.req && !prev.ack && !req;
        viol[2] = !prev.req && !prev.ack &&  ack;
        viol[3] =  prev.req &&  prev.ack && !ack;
    end

    always_comb begin
        hit = RULE_NONE;
        if (prev.armed) begin
            for (int i = NUM_RULES - 1; i >= 0; i--) begin
                if (viol[i]) begin
                    hit = rule_e'(CODE_W'(i + 1));
                end
            end
        end
    end

endmodule

// File: rtl/hs_sticky_latch.sv
module hs_sticky_latch
    import hs_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rule_e hit,
    output lat_t  rep
);

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (!lat_q.flag && hit != RULE_NONE) begin
            lat_d.flag = 1'b1;
            lat_d.code = hit;
        end
        if (rst) begin
            lat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        lat_q <= lat_d;
    end

    assign rep = lat_q;

endmodule

// File: rtl/hs_rtz_monitor.sv
module hs_rtz_monitor
    import hs_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              ack,
    output logic              err_flag,
    output logic [CODE_W-1:0] err_code
);

    smp_t  prev;
    rule_e hit;
    lat_t  rep;

    hs_edge_sampler u_sampler (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .ack  (ack),
        .prev (prev)
    );

    hs_rule_eval u_eval (
        .prev (prev),
        .req  (req),
        .ack  (ack),
        .hit  (hit)
    );

    hs_sticky_latch u_latch (
        .clk (clk),
        .rst (rst),
        .hit (hit),
        .rep (rep)
    );

    assign err_flag = rep.flag;
    assign err_code = rep.code;

endmodule

// File: rtl/hs_rtz_monitor_chk.sv
module hs_rtz_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       ack,
    input logic       err_flag,
    input logic [2:0] err_code
);

    // set after the first edge sampled outside reset
    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!err_flag && err_code == 3'd0));

    p_req_rearm_r2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !err_flag && !$past(req) && $past(ack) && req)
        |=> (err_flag && err_code == 3'd1));

    p_req_abandon_r3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !err_flag && $past(req) && !$past(ack) && !req)
        |=> (err_flag && err_code == 3'd2));

    p_ack_unasked_r4: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !err_flag && !$past(req) && !$past(ack) && ack)
        |=> (err_flag && err_code == 3'd3));

    p_ack_early_r5: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !err_flag && $past(req) && $past(ack) && !ack)
        |=> (err_flag && err_code == 3'd4));

    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> (err_flag && $stable(err_code)));

    p_code_range_r7: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (err_code >= 3'd1 && err_code <= 3'd4));

    p_first_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (!armed_q) |=> !err_flag);

endmodule

bind hs_rtz_monitor hs_rtz_monitor_chk chk_i (.*);

// File: tb/hs_rtz_monitor_tb_top.sv
module hs_rtz_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       ack = 1'b0;
    logic       err_flag;
    logic [2:0] err_code;

    int checks = 0;
    int errors = 0;

    // reference state built from the requirements
    logic m_armed = 1'b0;
    logic m_preq  = 1'b0;
    logic m_pack  = 1'b0;
    logic m_flag  = 1'b0;
    int   m_code  = 0;

    always #5ns clk = ~clk;

    hs_rtz_monitor dut_i (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .ack      (ack),
        .err_flag (err_flag),
        .err_code (err_code)
    );

    function automatic int rule_of(logic pr, logic pa, logic r, logic a);
        if (!pr &&  pa &&  r) return 1;
        if ( pr && !pa && !r) return 2;
        if (!pr && !pa &&  a) return 3;
        if ( pr &&  pa && !a) return 4;
        return 0;
    endfunction

    task automatic model_edge(logic r_rst, logic r, logic a);
        if (r_rst) begin
            m_armed = 1'b0; m_preq = 1'b0; m_pack = 1'b0;
            m_flag  = 1'b0; m_code = 0;
        end else begin
            if (m_armed && !m_flag && rule_of(m_preq, m_pack, r, a) != 0) begin
                m_flag = 1'b1;
                m_code = rule_of(m_preq, m_pack, r, a);
            end
            m_preq  = r;
            m_pack  = a;
            m_armed = 1'b1;
        end
    endtask

    task automatic check(string tag);
        checks++;
        if (err_flag !== m_flag || int'(err_code) != m_code) begin
            errors++;
            $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d",
                     tag, err_flag, err_code, m_flag, m_code);
        end
    endtask

    // drive away from the edge, then compare just after it
    task automatic step(logic r_rst, logic r, logic a, string tag);
        @(negedge clk);
        rst = r_rst; req = r; ack = a;
        @(posedge clk);
        #1ns;
        model_edge(r_rst, r, a);
        check(tag);
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic r, a;
        seed = 17;
        void'($urandom(seed));

        do_reset();
        step(1'b0, 1'b0, 1'b0, "R8");

        // R6: legal cycles with waits
        for (int n = 0; n < 3; n++) begin
            step(1'b0, 1'b1, 1'b0, "R6");
            step(1'b0, 1'b1, 1'b0, "R6");
            step(1'b0, 1'b1, 1'b1, "R6");
            step(1'b0, 1'b0, 1'b1, "R6");
            step(1'b0, 1'b0, 1'b1, "R6");
            step(1'b0, 1'b0, 1'b0, "R6");
        end

        // R2: req re-raised while ack high
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b1, 1'b1, "R2");

        // R3: req withdrawn early
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, "R3");

        // R4: spontaneous ack, then R7: later violations ignored
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, "R7");

        // R5: ack dropped under high req
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, "R7");

        // R8: illegal jump across the first edge after reset
        do_reset();
        step(1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, "R6");

        // R10: toggling under reset
        step(1'b1, 1'b0, 1'b1, "R10");
        step(1'b1, 1'b1, 1'b0, "R10");
        step(1'b1, 1'b0, 1'b0, "R10");
        step(1'b1, 1'b1, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");

        // random phase with periodic reset
        for (int n = 0; n < 2000; n++) begin
            if (n % 25 == 0) begin
                do_reset();
            end
            r = 1'($urandom);
            a = 1'($urandom);
            step(1'b0, r, a, "R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule